// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block drives the command pins of a two-bank graphics DRAM from the controller side. After reset it brings the memory up by closing every bank and then programming the operating mode word. From then on it keeps the array alive with periodic auto-refresh cycles. Each auto-refresh is preceded by a close of all banks, and the minimum spacing after every command is respected. The refresh period comes from the clock frequency parameter and the rule of 1024 refreshes per 16 ms.

A user port gets access through a simple request/grant pair. The sequencer grants only from its idle state and never takes the grant back. A refresh that falls due during a grant waits until the request drops, and it is performed before any new grant. A separate request input places the memory in self refresh, which the sequencer holds until that request is withdrawn. Between commands the pins carry a no-operation with chip select high.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset the pins show no-operation (cs_n high) with cke high, and ready and grant are low. After reset the first command is precharge-all (cs_n, ras_n, we_n low, cas_n high, dsf low, addr bit ADDR_W-1 high). Exactly T_RP cycles later comes the mode load (cs_n, ras_n, cas_n, we_n, dsf all low), with addr equal to MODE_ADDR and ba equal to MODE_BA.
- R2: ready first rises exactly T_RSC cycles after the mode load, and no other command comes before it.
- R3: Every auto-refresh, mode load and self-refresh entry follows a precharge-all issued exactly T_RP cycles earlier, with no command between them. Only the codes in R1, R7 and R9 ever appear.
- R4: No command follows an auto-refresh or a self-refresh exit within T_RC cycles, and none follows a mode load within T_RSC cycles.
- R5: With no grant and no self refresh in between, consecutive auto-refresh commands are exactly INTERVAL = floor(16*CLK_KHZ/1024) cycles apart.
- R6: While ready is high, cs_n is high and grant is low.
- R7: Auto-refresh is cs_n, ras_n, cas_n low with we_n, cke high and dsf low. From idle with no refresh due and no self-refresh request, a raised user_req gives grant on the next cycle. grant stays high while user_req stays high, and cs_n stays high during the grant.
- R8: A refresh that comes due during a grant is not issued until user_req drops. After that, precharge-all and auto-refresh are issued before grant is given again.
- R9: Self-refresh entry is the auto-refresh code with cke low. While sr_req stays high, cke stays low, cs_n stays high, and no further auto-refresh is issued.
- R10: One cycle after sr_req drops, cke is high. If nothing intervenes, the next auto-refresh comes exactly INTERVAL cycles after cke rises.
- R11: In idle, a pending refresh wins over sr_req, and sr_req wins over user_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| user_req | input | 1 | User port asks for access |
| sr_req | input | 1 | Request to enter and stay in self refresh |
| ready | output | 1 | High when the sequencer is idle |
| grant | output | 1 | Access granted to the user port |
| cke | output | 1 | DRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dsf | output | 1 | Special function select, held low |
| addr | output | ADDR_W | Address pins; top bit selects all banks on precharge |
| ba | output | 1 | Bank address |

## Verification
Some rules are checked on every cycle: the precharge-all before each refresh, mode load or self-refresh entry; the minimum gap after each command; quiet pins in idle, during a grant and during self refresh; and the sticky refresh-due flag. The bench scenarios are needed for the rest. They cover the exact power-up order and mode value, the refresh period over long idle stretches, and the deferral of a refresh behind a long grant. They also cover the restart of the interval after self-refresh exit and the priority among refresh, self-refresh and user requests.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the refresh and initialization sequencer.
// Assumes: one command per cycle; command codes are decoded into pins elsewhere.
package dram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_PREA,
        CMD_MRS,
        CMD_AREF,
        CMD_SREF
    } cmd_e;

    typedef enum logic [3:0] {
        S_RST,
        S_INIT_PRE,
        S_INIT_MRS,
        S_WAIT,
        S_IDLE,
        S_GRANT,
        S_PRE,
        S_AREF,
        S_SREF_IN,
        S_SELF,
        S_SREF_OUT
    } seq_state_e;

endpackage

// File: rtl/refresh_timer.sv
`timescale 1ns/1ps
// Down-counter that flags when the next auto-refresh is due.
// Assumes: reload is pulsed on each refresh and on self-refresh exit;
// pause holds the count while the memory refreshes itself.
module refresh_timer #(
    parameter int unsigned RELOAD_VAL = 3901
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic pause,
    output logic due
);
    localparam int CW = $clog2(RELOAD_VAL + 1);

    logic [CW-1:0] count_q;

    // Count down to zero, reload on request, hold while paused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= CW'(RELOAD_VAL);
        end else if (reload) begin
            count_q <= CW'(RELOAD_VAL);
        end else if (!pause && count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign due = (count_q == '0);

    // R5: once due, stays due until a reload clears it.
    a_r5_due_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        due && !reload |=> due);

    // R10: a reload starts a fresh, non-due interval.
    a_r10_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !due);

endmodule

// File: rtl/wait_timer.sv
`timescale 1ns/1ps
// Shared post-command wait counter.
// Assumes: loaded only in a command cycle with (gap - 1); last marks the
// final wait cycle, so the next command can start one cycle later.
module wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    // Load the wait length, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q <= W'(1));

    // R4: a new wait is never loaded over one still running.
    a_r4_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt_q == '0));

endmodule

// File: rtl/cmd_encoder.sv
`timescale 1ns/1ps
// Maps a command code onto the DRAM control and address pins.
// Assumes: the top address bit selects all banks on precharge; dsf stays low
// for every command this sequencer issues.
module cmd_encoder
    import dram_seq_pkg::*;
#(
    parameter int          ADDR_W    = 9,
    parameter int unsigned MODE_ADDR = 'h032,
    parameter bit          MODE_BA   = 1'b0
) (
    input  cmd_e              cmd,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              dsf,
    output logic [ADDR_W-1:0] addr,
    output logic              ba
);
    localparam int ALL_BANK_BIT = ADDR_W - 1;

    // Pin pattern for each command code.
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        dsf  = 1'b0;
        addr = '0;
        ba   = 1'b0;
        unique case (cmd)
            CMD_PREA: begin
                {cs_n, ras_n, cas_n, we_n} = 4'b0010;
                addr[ALL_BANK_BIT]         = 1'b1;
            end
            CMD_MRS: begin
                {cs_n, ras_n, cas_n, we_n} = 4'b0000;
                addr = ADDR_W'(MODE_ADDR);
                ba   = MODE_BA;
            end
            CMD_AREF, CMD_SREF: begin
                {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
// Top of the refresh and initialization sequencer.
// Brings the DRAM up (precharge-all, mode load), then schedules auto-refresh
// at the rate 1024 per 16 ms, serves a request/grant user port from idle, and
// enters/leaves self refresh on request.
// Assumes: T_RP, T_RSC, T_RC >= 1; INTERVAL well above T_RP + T_RC.
module dram_refresh_seq
    import dram_seq_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 250000,
    parameter int          T_RP      = 3,
    parameter int          T_RSC     = 2,
    parameter int          T_RC      = 8,
    parameter int          ADDR_W    = 9,
    parameter int unsigned MODE_ADDR = 'h032,
    parameter bit          MODE_BA   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_req,
    input  logic              sr_req,
    output logic              ready,
    output logic              grant,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              dsf,
    output logic [ADDR_W-1:0] addr,
    output logic              ba
);
    localparam int unsigned INTERVAL = (16 * CLK_KHZ) / 1024;
    localparam int unsigned RELOAD   = INTERVAL - T_RP - 2;
    localparam int TMAX   = (T_RC > T_RP) ? ((T_RC > T_RSC) ? T_RC : T_RSC)
                                          : ((T_RP > T_RSC) ? T_RP : T_RSC);
    localparam int WAIT_W = $clog2(TMAX + 1);
    localparam int GW     = WAIT_W + 1;

    seq_state_e        state_q, state_d;
    seq_state_e        after_q, after_d;
    cmd_e              cmd;
    logic              cke_low;
    logic              w_load;
    logic [WAIT_W-1:0] w_val;
    logic              w_last;
    logic              tmr_reload;
    logic              tmr_pause;
    logic              ref_due;

    // State and return-state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_RST;
            after_q <= S_IDLE;
        end else begin
            state_q <= state_d;
            after_q <= after_d;
        end
    end

    // Next state, command to issue, wait loads and timer control.
    always_comb begin
        state_d    = state_q;
        after_d    = after_q;
        cmd        = CMD_NOP;
        cke_low    = 1'b0;
        w_load     = 1'b0;
        w_val      = '0;
        tmr_reload = 1'b0;
        tmr_pause  = 1'b0;
        unique case (state_q)
            S_RST: begin
                tmr_reload = 1'b1;
                state_d    = S_INIT_PRE;
            end
            S_INIT_PRE: begin
                cmd        = CMD_PREA;
                tmr_reload = 1'b1;
                w_load     = 1'b1;
                w_val      = WAIT_W'(T_RP - 1);
                after_d    = S_INIT_MRS;
                state_d    = S_WAIT;
            end
            S_INIT_MRS: begin
                cmd        = CMD_MRS;
                tmr_reload = 1'b1;
                w_load     = 1'b1;
                w_val      = WAIT_W'(T_RSC - 1);
                after_d    = S_IDLE;
                state_d    = S_WAIT;
            end
            S_WAIT: begin
                if (w_last) state_d = after_q;
            end
            S_IDLE: begin
                if (ref_due) begin
                    after_d = S_AREF;
                    state_d = S_PRE;
                end else if (sr_req) begin
                    after_d = S_SREF_IN;
                    state_d = S_PRE;
                end else if (user_req) begin
                    state_d = S_GRANT;
                end
            end
            S_GRANT: begin
                if (!user_req) state_d = S_IDLE;
            end
            S_PRE: begin
                cmd     = CMD_PREA;
                w_load  = 1'b1;
                w_val   = WAIT_W'(T_RP - 1);
                state_d = S_WAIT;
            end
            S_AREF: begin
                cmd        = CMD_AREF;
                tmr_reload = 1'b1;
                w_load     = 1'b1;
                w_val      = WAIT_W'(T_RC - 1);
                after_d    = S_IDLE;
                state_d    = S_WAIT;
            end
            S_SREF_IN: begin
                cmd       = CMD_SREF;
                cke_low   = 1'b1;
                tmr_pause = 1'b1;
                state_d   = S_SELF;
            end
            S_SELF: begin
                cke_low   = 1'b1;
                tmr_pause = 1'b1;
                if (!sr_req) state_d = S_SREF_OUT;
            end
            S_SREF_OUT: begin
                tmr_reload = 1'b1;
                w_load     = 1'b1;
                w_val      = WAIT_W'(T_RC - 1);
                after_d    = S_IDLE;
                state_d    = S_WAIT;
            end
            default: state_d = S_RST;
        endcase
    end

    assign ready = (state_q == S_IDLE);
    assign grant = (state_q == S_GRANT);
    assign cke   = !cke_low;

    refresh_timer #(.RELOAD_VAL(RELOAD)) u_refresh_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (tmr_reload),
        .pause  (tmr_pause),
        .due    (ref_due)
    );

    wait_timer #(.W(WAIT_W)) u_wait_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (w_load),
        .load_val (w_val),
        .last     (w_last)
    );

    cmd_encoder #(
        .ADDR_W    (ADDR_W),
        .MODE_ADDR (MODE_ADDR),
        .MODE_BA   (MODE_BA)
    ) u_cmd_encoder (
        .cmd   (cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .dsf   (dsf),
        .addr  (addr),
        .ba    (ba)
    );

    // ---------------- assertions ----------------
    logic [GW-1:0] since_q;
    logic [GW-1:0] need_q;
    logic          prea_last_q;
    logic          cke_q;

    // Track cycles since the last command and the gap that command demands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q     <= '1;
            need_q      <= '0;
            prea_last_q <= 1'b0;
            cke_q       <= 1'b1;
        end else begin
            cke_q <= cke;
            if (!cs_n) begin
                since_q     <= GW'(1);
                prea_last_q <= (cmd == CMD_PREA);
                unique case (cmd)
                    CMD_PREA: need_q <= GW'(T_RP);
                    CMD_MRS:  need_q <= GW'(T_RSC);
                    CMD_AREF: need_q <= GW'(T_RC);
                    default:  need_q <= '0;
                endcase
            end else if (cke && !cke_q) begin
                since_q     <= GW'(1);
                need_q      <= GW'(T_RC);
                prea_last_q <= 1'b0;
            end else if (since_q != '1) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    a_r3_precharge_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n) |-> prea_last_q);

    a_r4_command_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (since_q >= need_q));

    a_r6_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cs_n && !grant && cke));

    a_r7_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> cs_n);

    a_r8_grant_release: assert property (@(posedge clk) disable iff (!rst_n)
        grant && !user_req |=> ready);

    a_r9_self_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !cke_q) |-> cs_n);

endmodule

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;
    localparam int T_RP     = 3;
    localparam int T_RSC    = 2;
    localparam int T_RC     = 8;
    localparam int ADDR_W   = 9;
    localparam int MODE     = 'h032;
    localparam int INTERVAL = (16 * 250000) / 1024;

    localparam int K_NONE = 0, K_PRE = 1, K_MRS = 2, K_REF = 3, K_SRE = 4, K_SRX = 5, K_BAD = 6;

    // {kind[31:30], hold[29:8], expected refreshes in window[7:0]}
    // kind: 0 idle, 1 user grant held, 2 self refresh held
    localparam logic [31:0] VEC [8] = '{
        {2'd0, 22'd11718, 8'd3},
        {2'd1, 22'd100,   8'd0},
        {2'd1, 22'd5000,  8'd0},
        {2'd2, 22'd2000,  8'd0},
        {2'd0, 22'd3906,  8'd1},
        {2'd2, 22'd9000,  8'd0},
        {2'd1, 22'd1,     8'd0},
        {2'd0, 22'd7812,  8'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic user_req = 1'b0;
    logic sr_req = 1'b0;
    logic ready, grant, cke, cs_n, ras_n, cas_n, we_n, dsf, ba;
    logic [ADDR_W-1:0] addr;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    dram_refresh_seq dut (
        .clk(clk), .rst_n(rst_n), .user_req(user_req), .sr_req(sr_req),
        .ready(ready), .grant(grant), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dsf(dsf), .addr(addr), .ba(ba)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Pin monitor state.
    int cyc, last_kind, last_cyc, anchor, n_ref, n_sre, n_prea, n_mrs;
    int prea_cyc, mrs_cyc, first_ready, kind, gap;
    int mrs_addr, mrs_ba;
    bit prev_cke, anchor_ok, anchor_srx, disturbed;

    // Decode pins each cycle and check ordering, gaps and spacing.
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; last_kind = K_NONE; last_cyc = 0; anchor = 0;
            n_ref = 0; n_sre = 0; n_prea = 0; n_mrs = 0;
            prea_cyc = 0; mrs_cyc = 0; first_ready = -1;
            prev_cke = 1'b1; anchor_ok = 1'b0; anchor_srx = 1'b0; disturbed = 1'b0;
        end else begin
            cyc++;
            if (ready && first_ready < 0) first_ready = cyc;
            if (grant || !cke) disturbed = 1'b1;
            if (cke && !prev_cke) begin
                last_kind = K_SRX; last_cyc = cyc;
                anchor = cyc; anchor_ok = 1'b1; anchor_srx = 1'b1; disturbed = 1'b0;
            end
            if (!cke && !prev_cke) chk(cs_n == 1'b1, "R9 cs_n high in self refresh", cs_n, 1);
            if (ready) chk(cs_n && !grant, "R6 idle pins quiet", {cs_n, grant}, 2);
            if (grant) chk(cs_n == 1'b1, "R7 no command during grant", cs_n, 1);
            if (!cs_n) begin
                gap = cyc - last_cyc;
                if (!ras_n && cas_n && !we_n) kind = K_PRE;
                else if (!ras_n && !cas_n && !we_n) kind = K_MRS;
                else if (!ras_n && !cas_n && we_n) kind = cke ? K_REF : K_SRE;
                else kind = K_BAD;
                chk(kind != K_BAD && dsf == 1'b0, "R3 legal command code",
                    {ras_n, cas_n, we_n, dsf}, 0);
                if (kind == K_PRE) begin
                    chk(addr[ADDR_W-1] == 1'b1, "R3 precharge selects all banks", addr[ADDR_W-1], 1);
                    n_prea++; prea_cyc = cyc;
                end else begin
                    chk(last_kind == K_PRE && gap == T_RP, "R3 precharge-all T_RP before",
                        gap, T_RP);
                end
                if (last_kind == K_REF || last_kind == K_SRX)
                    chk(gap >= T_RC, "R4 row-cycle gap", gap, T_RC);
                if (last_kind == K_MRS)
                    chk(gap >= T_RSC, "R4 register-set gap", gap, T_RSC);
                if (kind == K_MRS) begin
                    n_mrs++; mrs_cyc = cyc; mrs_addr = int'(addr); mrs_ba = int'(ba);
                end
                if (kind == K_REF) begin
                    n_ref++;
                    if (anchor_ok && !disturbed) begin
                        if (anchor_srx) chk(cyc - anchor == INTERVAL, "R10 interval restarts on exit",
                                            cyc - anchor, INTERVAL);
                        else chk(cyc - anchor == INTERVAL, "R5 refresh spacing",
                                 cyc - anchor, INTERVAL);
                    end
                    anchor = cyc; anchor_ok = 1'b1; anchor_srx = 1'b0; disturbed = 1'b0;
                end
                if (kind == K_SRE) n_sre++;
                last_kind = kind; last_cyc = cyc;
            end
            prev_cke = cke;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            compared++; mismatched++;
            $display("FAIL watchdog (all requirements): actual=%0d expected=%0d", wd, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wait_ready(input string req);
        int n = 0;
        while (!ready && n < 200) begin step(); n++; end
        chk(ready == 1'b1, req, ready, 1);
    endtask

    initial begin
        int r0, s0, n, knd, hold, expn;
        bit saw;
        // Reset state (R1)
        repeat (3) step();
        chk(cs_n == 1'b1 && cke == 1'b1, "R1 reset pins nop, cke high", {cs_n, cke}, 3);
        chk(ready == 1'b0 && grant == 1'b0, "R1 reset ready/grant low", {ready, grant}, 0);
        rst_n = 1'b1;
        wait_ready("R2 ready after init");
        chk(n_prea == 1 && n_mrs == 1, "R1 init command count", n_prea * 10 + n_mrs, 11);
        chk(mrs_cyc - prea_cyc == T_RP, "R1 mode load after precharge", mrs_cyc - prea_cyc, T_RP);
        chk(mrs_addr == MODE && mrs_ba == 0, "R1 mode value", mrs_addr, MODE);
        chk(first_ready - mrs_cyc == T_RSC, "R2 ready timing", first_ready - mrs_cyc, T_RSC);

        // Vector table walk
        for (int i = 0; i < 8; i++) begin
            knd  = int'(VEC[i][31:30]);
            hold = int'(VEC[i][29:8]);
            expn = int'(VEC[i][7:0]);
            if (knd == 0) begin
                r0 = n_ref;
                repeat (hold) step();
                chk(n_ref - r0 == expn, "R5 refresh count in idle window", n_ref - r0, expn);
            end else if (knd == 1) begin
                user_req = 1'b1;
                n = 0;
                while (!grant && n < 100) begin step(); n++; end
                chk(grant == 1'b1, "R7 grant given", grant, 1);
                r0 = n_ref;
                repeat (hold) step();
                chk(grant == 1'b1, "R7 grant held", grant, 1);
                chk(n_ref - r0 == expn, "R8 no refresh during grant", n_ref - r0, expn);
                user_req = 1'b0;
                step();
                wait_ready("R8 release to idle");
            end else begin
                sr_req = 1'b1;
                s0 = n_sre;
                n = 0;
                while (cke && n < 100) begin step(); n++; end
                chk(cke == 1'b0, "R9 cke low on entry", cke, 0);
                chk(n_sre - s0 == 1, "R9 one entry command", n_sre - s0, 1);
                r0 = n_ref;
                repeat (hold) step();
                chk(cke == 1'b0 && n_ref == r0, "R9 held in self refresh", n_ref - r0, 0);
                sr_req = 1'b0;
                step();
                chk(cke == 1'b1, "R10 cke high one cycle after drop", cke, 1);
                wait_ready("R10 idle after exit");
            end
        end

        // Directed: grant latency from idle (R7)
        r0 = n_ref;
        n = 0;
        while (n_ref == r0 && n < INTERVAL + 100) begin step(); n++; end
        wait_ready("R7 idle before request");
        repeat (3) step();
        user_req = 1'b1;
        step();
        chk(grant == 1'b1, "R7 grant next cycle", grant, 1);
        user_req = 1'b0;
        step();
        wait_ready("R7 idle after drop");

        // Directed: refresh deferred behind a long grant (R8)
        user_req = 1'b1;
        n = 0;
        while (!grant && n < 100) begin step(); n++; end
        r0 = n_ref;
        repeat (INTERVAL + 200) step();
        chk(n_ref == r0 && grant == 1'b1, "R8 refresh held off while granted", n_ref - r0, 0);
        user_req = 1'b0;
        step();
        user_req = 1'b1;
        n = 0;
        while (!grant && n < 100) begin step(); n++; end
        chk(grant == 1'b1, "R8 regrant after refresh", grant, 1);
        chk(n_ref - r0 == 1, "R8 refresh before regrant", n_ref - r0, 1);
        user_req = 1'b0;
        step();
        wait_ready("R8 idle");

        // Directed: self refresh wins over user request (R11)
        sr_req = 1'b1;
        user_req = 1'b1;
        saw = 1'b0;
        n = 0;
        while (cke && n < 100) begin step(); if (grant) saw = 1'b1; n++; end
        chk(!saw && cke == 1'b0, "R11 self refresh before grant", saw, 0);
        repeat (50) step();
        sr_req = 1'b0;
        n = 0;
        while (!grant && n < 100) begin step(); n++; end
        chk(grant == 1'b1, "R11 user served after exit", grant, 1);
        user_req = 1'b0;
        step();
        wait_ready("R11 idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule